// File: doc/BRIEF.md
# Debug Data Watchpoint Comparator

This block watches every data access a processor core makes and decides whether it should raise a debug event. Two address compare registers can be used on their own as exact-match watchpoints, or joined into one watchpoint that matches under a bit mask, inside an address window, or outside it. Each watchpoint can be limited to supervisor or user accesses. It can also be limited by the translation-space bit of the access. Each watchpoint can also demand that the data carried by the access matches a reference value. The byte lanes of that value compare are combined with AND, OR or a paired AND-OR rule.

The caller presents one access per cycle with a valid strobe, together with the control word and the compare registers. One cycle later the block reports a match flag per comparator. It also reports a debug event. In synchronous mode the event is a one-cycle pulse tied to the access. In asynchronous mode it is a flag that stays set until software clears it.

The control word uses big-endian numbering, so control bit k is `ctrl[31-k]`. Data byte i is `acc_data[31-8i -: 8]`, which makes byte 0 the most significant byte.

Top module: `dbg_watch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hit1`, `hit2` and `dbg_event` are 0.
- R2: Privilege qualifiers sit at control bits 0:1 (comparator 1) and 4:5 (comparator 2). The code 00 accepts any access, 10 accepts only `acc_user`=0 and 11 accepts only `acc_user`=1.
- R3: Space qualifiers sit at control bits 2:3 (comparator 1) and 6:7 (comparator 2). The code 00 ignores `acc_ds`, 10 requires `acc_ds`=0 and 11 requires `acc_ds`=1.
- R4: The pairing mode sits at control bits 8:9. With pairing mode 00, comparator 1 hits on `acc_addr`==`adr1` and comparator 2 hits on `acc_addr`==`adr2`, each on its own qualifiers.
- R5: With pairing mode 01, the pair hits when `acc_addr` equals `adr1` on every bit position where `adr2` is 1.
- R6: With pairing mode 10, the pair hits when `adr1` <= `acc_addr` < `adr2` (unsigned).
- R7: With pairing mode 11, the pair hits when `acc_addr` < `adr1` or `acc_addr` >= `adr2` (unsigned).
- R8: In pairing modes 01, 10 and 11, only the qualifiers of comparator 1 apply. A pair hit sets `hit1` and `hit2` together.
- R9: A reserved code disables the comparator it belongs to, so that comparator never hits. The reserved codes are 01 in a qualifier and 00 in the mode of an enabled value compare. In a paired mode, a reserved code in comparator 1's qualifiers or in either enabled value mode disables the pair.
- R10: Value compare k is enabled by control bit 24 (k=1) or bit 25 (k=2). Its mode sits at bits 12:13 or 14:15, and its byte enables at bits 16:19 or 20:23, where bit 16+i (or 20+i) enables byte i. Byte i matches when it equals byte i of `val1` or `val2`. Mode 01 requires every enabled byte to match, mode 10 requires any enabled byte to match, and mode 11 requires (byte 0 and byte 1) or (byte 2 and byte 3). Disabled bytes do not take part.
- R11: An enabled value compare with an empty byte-enable mask never matches. A comparator hits only when its address condition and its enabled value condition both hold. In a paired mode, both enabled value conditions must hold.
- R12: When control bit 10 is 0, `dbg_event` is high in exactly the cycle after a valid access that hits either comparator.
- R13: When control bit 10 is 1, a hit sets `dbg_event` and it stays set until `evt_clr`. A hit in the same cycle as `evt_clr` leaves it set.
- R14: A cycle without `acc_valid` produces `hit1`=`hit2`=0 in the next cycle, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | AW | Access address |
| acc_data | input | 32 | Access data, byte 0 in bits 31:24 |
| acc_user | input | 1 | Problem-state bit (1 = user) |
| acc_ds | input | 1 | Data translation-space bit |
| ctrl | input | 32 | Control word, big-endian bit numbering |
| adr1 | input | AW | Address compare register 1 |
| adr2 | input | AW | Address compare register 2 |
| val1 | input | 32 | Reference data for value compare 1 |
| val2 | input | 32 | Reference data for value compare 2 |
| evt_clr | input | 1 | Clears the sticky asynchronous event |
| hit1 | output | 1 | Comparator 1 matched the previous access |
| hit2 | output | 1 | Comparator 2 matched the previous access |
| dbg_event | output | 1 | Debug event, pulsed or sticky |

## Verification
The bench builds the block with `AW`=16. In that address space, random addresses drawn near `adr1` and `adr2` often land exactly on the range edges and on the equality points. The exact, inclusive and exclusive compares are therefore hit and missed in both directions many times during the random phase. The data width stays at 32, so all four byte lanes and both pair groups of the AND-OR mode take part in the value compares.

// File: rtl/dbg_watch.sv
module dbg_watch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [31:0]   acc_data,
  input  logic          acc_user,
  input  logic          acc_ds,
  input  logic [31:0]   ctrl,
  input  logic [AW-1:0] adr1,
  input  logic [AW-1:0] adr2,
  input  logic [31:0]   val1,
  input  logic [31:0]   val2,
  input  logic          evt_clr,
  output logic          hit1,
  output logic          hit2,
  output logic          dbg_event
);

  localparam int NB = 4;

  // control fields, big-endian bit k lives at ctrl[31-k]
  wire [1:0] pr1   = ctrl[31:30];
  wire [1:0] sp1   = ctrl[29:28];
  wire [1:0] pr2   = ctrl[27:26];
  wire [1:0] sp2   = ctrl[25:24];
  wire [1:0] pmode = ctrl[23:22];
  wire       async = ctrl[21];

  logic [1:0][1:0]    vmode;
  logic [1:0][NB-1:0] vbe;
  logic [1:0]         ven;
  logic [1:0][31:0]   vref;
  logic [1:0]         vok;

  assign vmode[0] = ctrl[19:18];
  assign vmode[1] = ctrl[17:16];
  assign vbe[0]   = {ctrl[12], ctrl[13], ctrl[14], ctrl[15]};
  assign vbe[1]   = {ctrl[8],  ctrl[9],  ctrl[10], ctrl[11]};
  assign ven      = {ctrl[6], ctrl[7]};
  assign vref[0]  = val1;
  assign vref[1]  = val2;

  function automatic logic qual_ok(input logic [1:0] pr, input logic [1:0] sp,
                                   input logic user, input logic ds);
    logic p, s;
    p = (pr == 2'b00) || (pr == 2'b10 && !user) || (pr == 2'b11 && user);
    s = (sp == 2'b00) || (sp == 2'b10 && !ds)   || (sp == 2'b11 && ds);
    return p && s;
  endfunction

  for (genvar k = 0; k < 2; k++) begin : g_val
    logic [NB-1:0] bm, pass;
    logic all_m, any_m, pair_m, comb;
    for (genvar i = 0; i < NB; i++) begin : g_byte
      assign bm[i] = acc_data[31-8*i -: 8] == vref[k][31-8*i -: 8];
    end
    assign pass   = bm | ~vbe[k];
    assign all_m  = (|vbe[k]) && (&pass);
    assign any_m  = |(bm & vbe[k]);
    assign pair_m = ((vbe[k][0] | vbe[k][1]) & pass[0] & pass[1]) |
                    ((vbe[k][2] | vbe[k][3]) & pass[2] & pass[3]);
    always_comb begin
      case (vmode[k])
        2'b01:   comb = all_m;
        2'b10:   comb = any_m;
        2'b11:   comb = pair_m;
        default: comb = 1'b0;
      endcase
    end
    assign vok[k] = !ven[k] || comb;
  end

  wire q1 = qual_ok(pr1, sp1, acc_user, acc_ds);
  wire q2 = qual_ok(pr2, sp2, acc_user, acc_ds);
  wire below1 = acc_addr < adr1;
  wire below2 = acc_addr < adr2;

  logic h1_n, h2_n, pair_a;

  always_comb begin
    pair_a = 1'b0;
    h1_n   = 1'b0;
    h2_n   = 1'b0;
    case (pmode)
      2'b00: begin
        h1_n = q1 && (acc_addr == adr1) && vok[0];
        h2_n = q2 && (acc_addr == adr2) && vok[1];
      end
      2'b01:   pair_a = ((acc_addr ^ adr1) & adr2) == '0;
      2'b10:   pair_a = !below1 && below2;
      default: pair_a = below1 || !below2;
    endcase
    if (pmode != 2'b00) begin
      h1_n = q1 && pair_a && vok[0] && vok[1];
      h2_n = h1_n;
    end
  end

  wire any_hit = acc_valid && (h1_n || h2_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit1      <= 1'b0;
      hit2      <= 1'b0;
      dbg_event <= 1'b0;
    end else begin
      hit1      <= acc_valid && h1_n;
      hit2      <= acc_valid && h2_n;
      dbg_event <= async ? (any_hit || (dbg_event && !evt_clr)) : any_hit;
    end
  end

endmodule

// File: rtl/dbg_watch_chk.sv
module dbg_watch_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic [31:0]   ctrl,
  input logic          evt_clr,
  input logic          hit1,
  input logic          hit2,
  input logic          dbg_event
);

  a_r14_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !hit1 && !hit2);

  a_r8_pair_flags: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && ctrl[23:22] != 2'b00 |=> hit1 == hit2);

  a_r12_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[21] |=> dbg_event == (hit1 || hit2));

  a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[21] && dbg_event && !evt_clr |=> dbg_event);

  a_r9_reserved_priv: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && ctrl[31:30] == 2'b01 |=> !hit1);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !hit1 && !hit2 && !dbg_event);

endmodule

bind dbg_watch dbg_watch_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .ctrl(ctrl), .evt_clr(evt_clr), .hit1(hit1), .hit2(hit2),
  .dbg_event(dbg_event)
);

// File: tb/sim_dbg_watch.sv
module sim_dbg_watch;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [31:0]   acc_data = '0;
  logic          acc_user = 1'b0;
  logic          acc_ds = 1'b0;
  logic [31:0]   ctrl = '0;
  logic [AW-1:0] adr1 = '0;
  logic [AW-1:0] adr2 = '0;
  logic [31:0]   val1 = '0;
  logic [31:0]   val2 = '0;
  logic          evt_clr = 1'b0;
  logic          hit1, hit2, dbg_event;

  int checks = 0;
  int errors = 0;
  logic exp_evt = 1'b0;
  bit done = 1'b0;

  dbg_watch #(.AW(AW)) u0 (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] mkc(logic [1:0] pr1, logic [1:0] sp1,
      logic [1:0] pr2, logic [1:0] sp2, logic [1:0] pm, logic as,
      logic [1:0] vm1, logic [1:0] vm2, logic [3:0] be1, logic [3:0] be2,
      logic e1, logic e2);
    logic [31:0] c;
    c = '0;
    c[31:30] = pr1; c[29:28] = sp1; c[27:26] = pr2; c[25:24] = sp2;
    c[23:22] = pm;  c[21] = as;     c[19:18] = vm1; c[17:16] = vm2;
    for (int i = 0; i < 4; i++) begin
      c[15-i] = be1[i];
      c[11-i] = be2[i];
    end
    c[7] = e1; c[6] = e2;
    return c;
  endfunction

  function automatic logic q_ok(logic [1:0] pr, logic [1:0] sp, logic u, logic d);
    logic a, b;
    a = pr == 2'b00 ? 1'b1 : pr == 2'b10 ? !u : pr == 2'b11 ? u : 1'b0;
    b = sp == 2'b00 ? 1'b1 : sp == 2'b10 ? !d : sp == 2'b11 ? d : 1'b0;
    return a & b;
  endfunction

  function automatic logic v_ok(logic en, logic [1:0] m, logic [3:0] be,
                                logic [31:0] d, logic [31:0] r);
    logic [3:0] eq;
    logic res;
    int n_en, n_hit;
    if (!en) return 1'b1;
    n_en = 0; n_hit = 0;
    for (int i = 0; i < 4; i++) begin
      eq[i] = d[31-8*i -: 8] == r[31-8*i -: 8];
      if (be[i]) begin
        n_en++;
        if (eq[i]) n_hit++;
      end
    end
    case (m)
      2'b01: res = (n_en > 0) && (n_en == n_hit);
      2'b10: res = n_hit > 0;
      2'b11: res = ((be[0] || be[1]) && (eq[0] || !be[0]) && (eq[1] || !be[1])) ||
                   ((be[2] || be[3]) && (eq[2] || !be[2]) && (eq[3] || !be[3]));
      default: res = 1'b0;
    endcase
    return res;
  endfunction

  task automatic expect_hits(output logic e1, output logic e2);
    logic [3:0] be1, be2;
    logic va, vb, a;
    for (int i = 0; i < 4; i++) begin
      be1[i] = ctrl[15-i];
      be2[i] = ctrl[11-i];
    end
    va = v_ok(ctrl[7], ctrl[19:18], be1, acc_data, val1);
    vb = v_ok(ctrl[6], ctrl[17:16], be2, acc_data, val2);
    e1 = 1'b0; e2 = 1'b0;
    if (acc_valid) begin
      case (ctrl[23:22])
        2'b00: begin
          e1 = q_ok(ctrl[31:30], ctrl[29:28], acc_user, acc_ds) && acc_addr == adr1 && va;
          e2 = q_ok(ctrl[27:26], ctrl[25:24], acc_user, acc_ds) && acc_addr == adr2 && vb;
        end
        default: begin
          if (ctrl[23:22] == 2'b01)      a = (acc_addr & adr2) == (adr1 & adr2);
          else if (ctrl[23:22] == 2'b10) a = acc_addr >= adr1 && acc_addr < adr2;
          else                           a = acc_addr < adr1 || acc_addr >= adr2;
          e1 = a && va && vb && q_ok(ctrl[31:30], ctrl[29:28], acc_user, acc_ds);
          e2 = e1;
        end
      endcase
    end
  endtask

  task automatic check(string tag, logic a1, logic a2, logic ae);
    checks++;
    if (hit1 !== a1 || hit2 !== a2 || dbg_event !== ae) begin
      errors++;
      $display("FAIL %s: hit1/hit2/event actual %b%b%b expected %b%b%b",
               tag, hit1, hit2, dbg_event, a1, a2, ae);
    end
  endtask

  task automatic step(string tag);
    logic e1, e2;
    expect_hits(e1, e2);
    if (ctrl[21]) exp_evt = (e1 | e2) | (exp_evt & !evt_clr);
    else          exp_evt = e1 | e2;
    @(posedge clk);
    #2;
    check(tag, e1, e2, exp_evt);
    @(negedge clk);
  endtask

  task automatic acc(logic v, logic [AW-1:0] a, logic u, logic d);
    acc_valid = v; acc_addr = a; acc_user = u; acc_ds = d;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    #2;
    check("R1 in reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 after reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk);

    adr1 = 16'h1234; adr2 = 16'h5678;
    ctrl = mkc(0,0,0,0, 2'b00, 0, 0,0, 0,0, 0,0);
    acc(1, 16'h1234, 0, 0); step("R4 exact comp1");
    acc(1, 16'h5678, 1, 1); step("R4 exact comp2");
    acc(1, 16'h1235, 0, 0); step("R4 exact miss");
    acc(0, 16'h1234, 0, 0); step("R14 idle no hit");

    ctrl = mkc(2'b10,0,2'b11,0, 2'b00, 0, 0,0, 0,0, 0,0);
    acc(1, 16'h1234, 1, 0); step("R2 supervisor only vs user");
    acc(1, 16'h1234, 0, 0); step("R2 supervisor only vs supervisor");
    acc(1, 16'h5678, 1, 0); step("R2 user only vs user");
    ctrl = mkc(0,2'b10,0,2'b11, 2'b00, 0, 0,0, 0,0, 0,0);
    acc(1, 16'h1234, 0, 1); step("R3 ds must be 0, ds=1");
    acc(1, 16'h5678, 0, 1); step("R3 ds must be 1, ds=1");
    acc(1, 16'h5678, 0, 0); step("R3 ds must be 1, ds=0");

    ctrl = mkc(2'b01,0,0,0, 2'b00, 0, 0,0, 0,0, 0,0);
    acc(1, 16'h1234, 0, 0); step("R9 reserved priv comp1");
    ctrl = mkc(0,0,0,2'b01, 2'b00, 0, 0,0, 0,0, 0,0);
    acc(1, 16'h5678, 0, 0); step("R9 reserved space comp2");

    adr1 = 16'h1230; adr2 = 16'hFFF0;
    ctrl = mkc(0,0,2'b01,2'b01, 2'b01, 0, 0,0, 0,0, 0,0);
    acc(1, 16'h123F, 0, 0); step("R5 mask hit, R8 comp2 qual ignored");
    acc(1, 16'h1330, 0, 0); step("R5 mask miss");

    adr1 = 16'h0100; adr2 = 16'h0200;
    ctrl = mkc(0,0,0,0, 2'b10, 0, 0,0, 0,0, 0,0);
    acc(1, 16'h0100, 0, 0); step("R6 low edge");
    acc(1, 16'h01FF, 0, 0); step("R6 below high edge");
    acc(1, 16'h0200, 0, 0); step("R6 high edge excluded");
    acc(1, 16'h00FF, 0, 0); step("R6 below low edge");
    ctrl = mkc(0,0,0,0, 2'b11, 0, 0,0, 0,0, 0,0);
    acc(1, 16'h00FF, 0, 0); step("R7 below low");
    acc(1, 16'h0100, 0, 0); step("R7 low edge inside");
    acc(1, 16'h01FF, 0, 0); step("R7 inside");
    acc(1, 16'h0200, 0, 0); step("R7 high edge");
    ctrl = mkc(2'b10,0,0,0, 2'b11, 0, 0,0, 0,0, 0,0);
    acc(1, 16'h0200, 1, 0); step("R8 comp1 qual applies in pair");

    adr1 = 16'h4000; adr2 = 16'h4000;
    val1 = 32'hAABBCCDD; val2 = 32'h11223344;
    acc(1, 16'h4000, 0, 0);
    acc_data = 32'hAABB0000;
    ctrl = mkc(0,0,0,0, 2'b00, 0, 2'b01,2'b01, 4'b0011,4'b0011, 1,0);
    step("R10 AND bytes 0,1 hit");
    ctrl = mkc(0,0,0,0, 2'b00, 0, 2'b01,2'b01, 4'b0111,4'b0011, 1,0);
    step("R10 AND byte 2 missing");
    ctrl = mkc(0,0,0,0, 2'b00, 0, 2'b10,2'b01, 4'b1100,4'b0011, 1,0);
    step("R10 OR no enabled byte matches");
    acc_data = 32'h0000CC00;
    step("R10 OR byte 2 matches");
    acc_data = 32'h0000CCDD;
    ctrl = mkc(0,0,0,0, 2'b00, 0, 2'b11,2'b01, 4'b1111,4'b0011, 1,0);
    step("R10 pair bytes 2,3");
    acc_data = 32'hAA00CC00;
    step("R10 pair split miss");
    ctrl = mkc(0,0,0,0, 2'b00, 0, 2'b00,2'b01, 4'b1111,4'b0011, 1,0);
    acc_data = 32'hAABBCCDD;
    step("R9 reserved value mode");
    ctrl = mkc(0,0,0,0, 2'b00, 0, 2'b10,2'b01, 4'b0000,4'b0011, 1,0);
    step("R11 empty mask");
    acc_data = 32'h11223344;
    ctrl = mkc(0,0,0,0, 2'b10, 0, 2'b01,2'b01, 4'b1111,4'b1111, 1,1);
    adr1 = 16'h3000; adr2 = 16'h5000;
    step("R11 paired needs both values");
    ctrl = mkc(0,0,0,0, 2'b10, 0, 2'b01,2'b01, 4'b1111,4'b1111, 0,1);
    step("R11 paired value 2 only");

    ctrl = mkc(0,0,0,0, 2'b10, 0, 0,0, 0,0, 0,0);
    acc(1, 16'h4000, 0, 0); step("R12 sync pulse");
    acc(0, 16'h4000, 0, 0); step("R12 pulse ends");
    ctrl[21] = 1'b1;
    acc(1, 16'h4000, 0, 0); step("R13 async set");
    acc(0, 16'h0000, 0, 0); step("R13 holds");
    step("R13 still holds");
    evt_clr = 1'b1; acc(1, 16'h4000, 0, 0); step("R13 set beats clear");
    acc(0, 16'h0000, 0, 0); step("R13 clear");
    evt_clr = 1'b0; step("R13 stays clear");

    for (int n = 0; n < 4000; n++) begin
      logic [3:0] pick;
      pick = 4'($urandom_range(0, 9));
      adr1 = AW'($urandom_range(0, 255));
      adr2 = adr1 + AW'($urandom_range(0, 255));
      if ($urandom_range(0, 7) == 0) adr2 = AW'($urandom);
      case (pick)
        0, 1: acc_addr = adr1;
        2, 3: acc_addr = adr2;
        4:    acc_addr = adr1 - 1'b1;
        5:    acc_addr = adr2 - 1'b1;
        6:    acc_addr = AW'($urandom);
        default: acc_addr = adr1 + AW'($urandom_range(0, 300));
      endcase
      val1 = $urandom; val2 = $urandom;
      acc_data = $urandom_range(0, 1) != 0 ? val1 : val2;
      for (int i = 0; i < 4; i++)
        if ($urandom_range(0, 3) == 0) acc_data[31-8*i -: 8] = 8'($urandom);
      ctrl = $urandom;
      if ($urandom_range(0, 1) != 0) ctrl[7:6] = 2'b00;
      acc_valid = $urandom_range(0, 7) != 0;
      acc_user = 1'($urandom); acc_ds = 1'($urandom);
      evt_clr = $urandom_range(0, 5) == 0;
      step("R10 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule